// File: doc/BRIEF.md
# Global Manual Error Insert Trigger

This block turns a single manual "insert an error now" command into one error-insertion pulse for each port that takes part in global insertion. The command comes from one of two places: a software-written control bit or an external input pin. A select input decides which one is used. The pin is asynchronous, so it passes through a two-flop synchronizer first. Only a low-to-high transition of the chosen source counts as a command. Holding the source high does not issue further commands.

A detected command does not corrupt anything at once. Each port has a small request state machine with two states, `REQ_IDLE` and `REQ_PEND`. A command moves a port from `REQ_IDLE` to `REQ_PEND`, but only if that port's global-enable bit is 1 in the cycle the command is seen. The port leaves `REQ_PEND` at its next insertion-opportunity strobe, which comes from the port's framing logic. In that same cycle the port's insert output pulses high for one cycle. A command that arrives while a port is in `REQ_PEND` merges with the request already waiting. A command that lands in the very cycle of release keeps the port in `REQ_PEND`, so that command is served at the following opportunity.

The source edge detector is a three-state machine:

- `SRC_SEED` is entered from reset. It loads the reference level from the selected source and raises nothing.
- `SRC_WATCH_SW` watches the control bit. It moves to `SRC_WATCH_PIN` when the select input goes to 1.
- `SRC_WATCH_PIN` watches the synchronized pin. It moves to `SRC_WATCH_SW` when the select input goes to 0.

On every switch of source, the reference level is reloaded from the newly chosen source, so a switch can never look like an edge. The per-port transitions are:

- `REQ_IDLE` to `REQ_PEND` on a command while the port is enabled.
- `REQ_PEND` to `REQ_IDLE` on an opportunity strobe with no new command.
- `REQ_PEND` stays in `REQ_PEND` on an opportunity strobe that coincides with a new command while the port is enabled.

Top module: `gmei_trigger`

## Requirements
- R1: A command is raised only in the first cycle in which the chosen source is seen high after being low; holding the source high for many cycles produces exactly one command.
- R2: With `pin_mode` = 0 the control bit `sw_insert` is the source, and a rise of it seen at clock edge k makes the port pending from cycle k+1. With `pin_mode` = 1 the source is `ext_insert_pin` after a two-flop synchronizer, so a rise driven before edge k is detected in the cycle after edge k+1.
- R3: While `pin_mode` = 1, transitions of `sw_insert` have no effect on any output; while `pin_mode` = 0, transitions of `ext_insert_pin` have no effect on any output.
- R4: A command makes port i pending only if bit i of `port_global_en` is 1 in the cycle the command is raised; ports whose bit is 0 never pulse for that command.
- R5: `port_insert[i]` is high for exactly the first cycle, after the command cycle, in which `port_opp[i]` is 1. An opportunity in the command cycle itself does not count. After the pulse the port is idle.
- R6: A second command raised while port i is still pending, and not in its release cycle, merges with the waiting request, so only one pulse follows.
- R7: A command raised in the same cycle that port i pulses, with the port enabled, leaves port i pending, so a second pulse comes at its next opportunity.
- R8: In a cycle where `pin_mode` differs from its value in the previous cycle, no command is raised, and the new source's current level becomes the reference, so a source that is already high produces no command after the switch.
- R9: While `rst_n` is 0 and right after its release, all `port_insert` bits are 0. Pending requests are cleared, and a source already high when reset is released raises no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_insert | input | 1 | Software manual-insert control bit |
| pin_mode | input | 1 | Source select: 0 = control bit, 1 = external pin |
| ext_insert_pin | input | 1 | Asynchronous external insert pin |
| port_global_en | input | NPORTS | Per-port enable for global insertion |
| port_opp | input | NPORTS | Per-port insertion-opportunity strobe |
| port_insert | output | NPORTS | Per-port single-cycle insert pulse |

## Verification
The bench holds each source high for several cycles, because an edge detector that works on levels would pulse again on every opportunity. It raises commands while requests are waiting and in the exact release cycle. A design that queues commands would give an extra pulse in the first case, and one that drops commands would miss the second pulse in the other. It switches the source select while the newly chosen source is already high, and it releases reset with the control bit high; a detector that keeps a stale reference would then insert a false error. It also toggles the unselected source and places an opportunity in the command cycle itself, which expose wrong source muxing and pulses that come one cycle early.

// File: rtl/gmei_pkg.sv
package gmei_pkg;

    typedef enum logic [1:0] {
        SRC_SEED      = 2'd0,
        SRC_WATCH_SW  = 2'd1,
        SRC_WATCH_PIN = 2'd2
    } src_state_t;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_PEND = 1'b1
    } req_state_t;

endpackage

// File: rtl/gmei_sync.sv
module gmei_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= 1'b0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[LAST];
endmodule

// File: rtl/gmei_edge.sv
module gmei_edge
    import gmei_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_mode,
    input  logic sw_bit,
    input  logic pin_s,
    output logic trig
);
    src_state_t state, state_nxt, wanted;
    logic       cur_lvl;
    logic       ref_lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SRC_SEED;
        else        state <= state_nxt;
    end

    // reference level always follows the currently selected source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_lvl <= 1'b0;
        else        ref_lvl <= pin_mode ? pin_s : sw_bit;
    end

    // next-state logic
    always_comb begin
        wanted    = pin_mode ? SRC_WATCH_PIN : SRC_WATCH_SW;
        state_nxt = state;
        unique case (state)
            SRC_SEED:      state_nxt = wanted;
            SRC_WATCH_SW:  if (pin_mode)  state_nxt = SRC_WATCH_PIN;
            SRC_WATCH_PIN: if (!pin_mode) state_nxt = SRC_WATCH_SW;
            default:       state_nxt = SRC_SEED;
        endcase
    end

    // outputs
    always_comb begin
        cur_lvl = 1'b0;
        trig    = 1'b0;
        unique case (state)
            SRC_SEED: begin
                cur_lvl = 1'b0;
                trig    = 1'b0;
            end
            SRC_WATCH_SW: begin
                cur_lvl = sw_bit;
                trig    = !pin_mode && cur_lvl && !ref_lvl;
            end
            SRC_WATCH_PIN: begin
                cur_lvl = pin_s;
                trig    = pin_mode && cur_lvl && !ref_lvl;
            end
            default: begin
                cur_lvl = 1'b0;
                trig    = 1'b0;
            end
        endcase
    end

    // R1: a command never repeats on the following cycle
    a_r1_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);

    // R3: in pin mode with a steady pin, the control bit cannot raise anything
    a_r3_sw_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode && $past(pin_mode) && $stable(pin_s)) |-> !trig);

    // R8: a select change never raises a command
    a_r8_no_false_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode != $past(pin_mode)) |-> !trig);
endmodule

// File: rtl/gmei_port_req.sv
module gmei_port_req
    import gmei_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic en,
    input  logic opp,
    output logic ins
);
    req_state_t state, state_nxt;
    logic       take;

    assign take = trig && en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= REQ_IDLE;
        else        state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            REQ_IDLE: if (take) state_nxt = REQ_PEND;
            REQ_PEND: if (opp && !take) state_nxt = REQ_IDLE;
            default:  state_nxt = REQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ins = 1'b0;
        unique case (state)
            REQ_IDLE: ins = 1'b0;
            REQ_PEND: ins = opp;
            default:  ins = 1'b0;
        endcase
    end

    // R5: a pulse needs a request raised or waiting in the previous cycle
    a_r5_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ins |-> ($past(take) || $past(state == REQ_PEND)));

    // R4: an idle, disabled port gives no pulse next cycle
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REQ_IDLE && !en) |=> !ins);

    // R6: a waiting request survives until an opportunity
    a_r6_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REQ_PEND && !opp) |=> (state == REQ_PEND));

    // R7: a command in the release cycle re-arms the port
    a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (ins && take) |=> (state == REQ_PEND));
endmodule

// File: rtl/gmei_trigger.sv
module gmei_trigger
    import gmei_pkg::*;
#(
    parameter int NPORTS      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_insert,
    input  logic              pin_mode,
    input  logic              ext_insert_pin,
    input  logic [NPORTS-1:0] port_global_en,
    input  logic [NPORTS-1:0] port_opp,
    output logic [NPORTS-1:0] port_insert
);
    logic pin_s;
    logic trig;

    gmei_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ext_insert_pin),
        .q_sync  (pin_s)
    );

    gmei_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_mode (pin_mode),
        .sw_bit   (sw_insert),
        .pin_s    (pin_s),
        .trig     (trig)
    );

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            gmei_port_req u_req (
                .clk   (clk),
                .rst_n (rst_n),
                .trig  (trig),
                .en    (port_global_en[p]),
                .opp   (port_opp[p]),
                .ins   (port_insert[p])
            );
        end
    endgenerate

    // R5: an insert pulse only appears with that port's opportunity strobe
    a_r5_pulse_with_opp: assert property (@(posedge clk) disable iff (!rst_n)
        (port_insert & ~port_opp) == '0);

    // R9: outputs are quiet in the first cycle after reset release
    a_r9_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (port_insert == '0));
endmodule

// File: tb/gmei_trigger_test.sv
module gmei_trigger_test;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sw_insert, pin_mode, ext_insert_pin;
    logic [NP-1:0] port_global_en, port_opp, port_insert;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    gmei_trigger #(.NPORTS(NP), .SYNC_STAGES(2)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sw_insert      (sw_insert),
        .pin_mode       (pin_mode),
        .ext_insert_pin (ext_insert_pin),
        .port_global_en (port_global_en),
        .port_opp       (port_opp),
        .port_insert    (port_insert)
    );

    // fields: [18:15] requirement, [14] mode, [13] sw, [12] pin,
    //         [11:8] enable, [7:4] opportunity, [3:0] expected insert
    localparam int NV = 40;
    localparam logic [18:0] VEC [0:NV-1] = '{
        {4'd1, 1'b0,1'b0,1'b0, 4'hF,4'h0, 4'h0}, // 0  idle
        {4'd5, 1'b0,1'b1,1'b0, 4'hF,4'hF, 4'h0}, // 1  sw rise, opp in command cycle: R5
        {4'd2, 1'b0,1'b1,1'b0, 4'hF,4'h1, 4'h1}, // 2  port0 pulse: R2
        {4'd5, 1'b0,1'b1,1'b0, 4'hF,4'hF, 4'hE}, // 3  rest pulse, port0 done: R5
        {4'd1, 1'b0,1'b1,1'b0, 4'hF,4'hF, 4'h0}, // 4  level held: R1
        {4'd1, 1'b0,1'b0,1'b0, 4'h5,4'h0, 4'h0}, // 5
        {4'd4, 1'b0,1'b1,1'b0, 4'h5,4'h0, 4'h0}, // 6  rise with mask 0101
        {4'd4, 1'b0,1'b0,1'b0, 4'hF,4'hF, 4'h5}, // 7  only masked ports: R4
        {4'd3, 1'b0,1'b0,1'b1, 4'hF,4'h0, 4'h0}, // 8  pin toggles while sw selected
        {4'd3, 1'b0,1'b0,1'b1, 4'hF,4'h0, 4'h0}, // 9
        {4'd3, 1'b0,1'b0,1'b0, 4'hF,4'hF, 4'h0}, // 10 R3
        {4'd8, 1'b0,1'b0,1'b1, 4'hF,4'h0, 4'h0}, // 11 pin high
        {4'd8, 1'b0,1'b0,1'b1, 4'hF,4'h0, 4'h0}, // 12
        {4'd8, 1'b1,1'b0,1'b1, 4'hF,4'h0, 4'h0}, // 13 switch to pin, pin high
        {4'd8, 1'b1,1'b0,1'b1, 4'hF,4'h0, 4'h0}, // 14
        {4'd8, 1'b1,1'b0,1'b1, 4'hF,4'hF, 4'h0}, // 15 no false edge: R8
        {4'd3, 1'b1,1'b1,1'b1, 4'hF,4'hF, 4'h0}, // 16 sw rise ignored
        {4'd3, 1'b1,1'b0,1'b0, 4'hF,4'hF, 4'h0}, // 17 R3
        {4'd2, 1'b1,1'b0,1'b0, 4'hF,4'h0, 4'h0}, // 18
        {4'd2, 1'b1,1'b0,1'b1, 4'hF,4'h0, 4'h0}, // 19 pin rise
        {4'd2, 1'b1,1'b0,1'b1, 4'hF,4'h0, 4'h0}, // 20
        {4'd2, 1'b1,1'b0,1'b1, 4'hF,4'hF, 4'h0}, // 21 detected here, opp same cycle
        {4'd5, 1'b1,1'b0,1'b0, 4'hF,4'h0, 4'h0}, // 22 waiting
        {4'd2, 1'b1,1'b0,1'b0, 4'hF,4'h3, 4'h3}, // 23 ports 0,1 pulse: R2
        {4'd6, 1'b1,1'b0,1'b1, 4'hF,4'h0, 4'h0}, // 24 pin rise, ports 2,3 waiting
        {4'd6, 1'b1,1'b0,1'b0, 4'hF,4'h0, 4'h0}, // 25
        {4'd6, 1'b1,1'b0,1'b0, 4'hF,4'h0, 4'h0}, // 26 second command merges
        {4'd6, 1'b1,1'b0,1'b0, 4'hF,4'hF, 4'hF}, // 27 one pulse each
        {4'd6, 1'b1,1'b0,1'b0, 4'hF,4'hF, 4'h0}, // 28 nothing queued: R6
        {4'd8, 1'b0,1'b0,1'b0, 4'hF,4'h0, 4'h0}, // 29 back to sw
        {4'd7, 1'b0,1'b1,1'b0, 4'hF,4'h0, 4'h0}, // 30 command
        {4'd7, 1'b0,1'b0,1'b0, 4'hF,4'h0, 4'h0}, // 31
        {4'd7, 1'b0,1'b1,1'b0, 4'hF,4'hF, 4'hF}, // 32 release + new command
        {4'd7, 1'b0,1'b1,1'b0, 4'hF,4'hF, 4'hF}, // 33 re-armed pulse: R7
        {4'd7, 1'b0,1'b0,1'b0, 4'hF,4'hF, 4'h0}, // 34
        {4'd8, 1'b1,1'b1,1'b0, 4'hF,4'h0, 4'h0}, // 35 to pin, sw high
        {4'd8, 1'b1,1'b1,1'b0, 4'hF,4'h0, 4'h0}, // 36
        {4'd8, 1'b0,1'b1,1'b0, 4'hF,4'h0, 4'h0}, // 37 to sw while sw high
        {4'd8, 1'b0,1'b1,1'b0, 4'hF,4'hF, 4'h0}, // 38 R8
        {4'd8, 1'b0,1'b0,1'b0, 4'hF,4'hF, 4'h0}  // 39
    };

    task automatic drive(input logic m, input logic s, input logic p,
                         input logic [NP-1:0] e, input logic [NP-1:0] o);
        @(negedge clk);
        pin_mode       = m;
        sw_insert      = s;
        ext_insert_pin = p;
        port_global_en = e;
        port_opp       = o;
    endtask

    task automatic check(input string tag, input logic [NP-1:0] exp);
        #4;
        n_cmp++;
        if (port_insert !== exp) begin
            n_bad++;
            $display("FAIL %s: port_insert=%b expected %b", tag, port_insert, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected <= 5000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 4'hF, 4'hF);
        check("R9 in reset", 4'h0);
        drive(1'b0, 1'b0, 1'b0, 4'hF, 4'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:8], VEC[i][7:4]);
            check($sformatf("R%0d vector %0d", VEC[i][18:15], i), VEC[i][3:0]);
        end

        // R9: control bit high across reset release is not a command
        drive(1'b0, 1'b1, 1'b0, 4'hF, 4'h0);
        rst_n = 1'b0;
        drive(1'b0, 1'b1, 1'b0, 4'hF, 4'h0);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 4'hF, 4'hF);
        check("R9 release with source high", 4'h0);
        drive(1'b0, 1'b1, 1'b0, 4'hF, 4'hF);
        check("R9 release with source high", 4'h0);

        // R9: reset wipes a waiting request
        drive(1'b0, 1'b0, 1'b0, 4'hF, 4'h0);
        drive(1'b0, 1'b1, 1'b0, 4'hF, 4'h0);
        drive(1'b0, 1'b0, 1'b0, 4'hF, 4'h0);
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 4'hF, 4'h0);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 4'hF, 4'hF);
        check("R9 pending cleared", 4'h0);

        // R5: opportunity on a single port only releases that port
        drive(1'b0, 1'b1, 1'b0, 4'hF, 4'h0);
        drive(1'b0, 1'b0, 1'b0, 4'hF, 4'h8);
        check("R5 single port release", 4'h8);
        drive(1'b0, 1'b0, 1'b0, 4'hF, 4'h8);
        check("R5 no second pulse", 4'h0);
        drive(1'b0, 1'b0, 1'b0, 4'hF, 4'h7);
        check("R5 remaining ports", 4'h7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule